// File: doc/BRIEF.md
# Dual-Issue Memory Operation Scheduler

This block sits between the front end of a processor and a banked data cache. It takes memory operations (loads and stores) into a shared four-entry holding queue, two at a time. Each clock it sends up to two of them to the cache on two parallel request ports.

The oldest queued operation always goes out on port 0, unless it is a store and the store buffer has no room. A second operation goes out on port 1 only when the pair is legal:
- The pair must be two loads, or one load and one store. Two stores never issue together.
- A load and a store paired together must not target the same cache index and the same bank.
- Neither operation may carry a special attribute that demands a lone access.

Issued stores are written into a four-entry store buffer. The buffer keeps speculative store data until a commit releases its oldest entry to the cache. A flush discards every queued operation and every uncommitted store.

Issue is strictly in age order. If the oldest operation cannot go, nothing goes that clock.

Top module: `lss_sched_top`

## Requirements
- R1: After reset no request port is valid, `enq_ready` is 1 and `drain_valid` is 0.
- R2: The oldest queued operation is presented on port 0 (bit 0 of each `iss_*` vector, low field of each packed bus). If it cannot issue, port 1 stays idle as well.
- R3: When the two oldest operations are both loads without special attributes, both issue in the same clock. The older one uses port 0 and the younger one uses port 1.
- R4: Two stores never issue in the same clock. The younger store waits and issues alone on port 0 in a later clock.
- R5: A load and a store with equal index and equal bank issue in separate clocks. If either the index or the bank differs, they issue together.
- R6: Each operation has a 5-bit attribute field: bit 0 I/O load, bit 1 locked access, bit 2 segment-descriptor load, bit 3 data breakpoint, bit 4 first half of a misaligned access. If any attribute bit is set on either of the two oldest operations, only one operation issues that clock.
- R7: An issued store is written into the store buffer. While the store buffer holds 4 entries, no store issues on either port.
- R8: `drain_valid` is high while the store buffer holds an entry. The `drain_*` outputs show the oldest entry, and a high `commit` removes it. Entries leave in issue order.
- R9: While `flush` is high no port is valid and enqueues are ignored. After that clock the holding queue and the store buffer are empty.
- R10: The holding queue holds up to 4 operations, taking up to two per clock. `enq_ready` is high only while at least two slots are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all queued operations and uncommitted stores |
| enq_valid | input | 2 | Enqueue lane valid; lane 0 is older |
| enq_store | input | 2 | Lane carries a store (1) or a load (0) |
| enq_attr | input | 10 | Per-lane 5-bit attribute field |
| enq_idx | input | 12 | Per-lane 6-bit cache index |
| enq_bank | input | 4 | Per-lane 2-bit cache bank |
| enq_tag | input | 8 | Per-lane 4-bit operation tag |
| enq_data | input | 32 | Per-lane 16-bit store data |
| enq_ready | output | 1 | Two free slots in the holding queue |
| iss_valid | output | 2 | Request port valid, bit 0 = port 0 |
| iss_store | output | 2 | Request is a store |
| iss_idx | output | 12 | Per-port cache index |
| iss_bank | output | 4 | Per-port cache bank |
| iss_tag | output | 8 | Per-port operation tag |
| commit | input | 1 | Release the oldest store-buffer entry |
| drain_valid | output | 1 | Store buffer not empty |
| drain_idx | output | 6 | Index of the oldest store |
| drain_bank | output | 2 | Bank of the oldest store |
| drain_data | output | 16 | Data of the oldest store |

## Verification
The bench uses the default depths of four for the holding queue and four for the store buffer. With these depths, five stores are enough to fill the store buffer and stall a store at the head. Queuing loads behind that stalled store then fills the holding queue, so `enq_ready` drops.

Releasing one entry afterwards shows the stalled store leave in a pair with a load. The same run covers colliding and non-colliding load/store pairs, store pairs, and both attribute positions. It ends with a flush issued while operations and stores are still pending.

// File: rtl/lss_pkg.sv
package lss_pkg;
    parameter int IDX_W  = 6;
    parameter int BANK_W = 2;
    parameter int TAG_W  = 4;
    parameter int DATA_W = 16;
    parameter int ATTR_W = 5;

    typedef struct packed {
        logic              is_st;
        logic [ATTR_W-1:0] attr;
        logic [IDX_W-1:0]  idx;
        logic [BANK_W-1:0] bank;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } mem_op_t;
endpackage

// File: rtl/lss_pair.sv
module lss_pair
    import lss_pkg::*;
(
    input  mem_op_t head,
    input  logic    head_v,
    input  mem_op_t nxt,
    input  logic    nxt_v,
    input  logic    sb_room,
    output logic    go0,
    output logic    go1
);
    logic same_slot, mixed, lone;

    always_comb begin
        same_slot = (head.idx == nxt.idx) && (head.bank == nxt.bank);
        mixed     = head.is_st ^ nxt.is_st;
        lone      = (|head.attr) || (|nxt.attr);
        go0 = head_v && (!head.is_st || sb_room);
        go1 = go0 && nxt_v && !lone
              && !(head.is_st && nxt.is_st)
              && !(nxt.is_st && !sb_room)
              && !(mixed && same_slot);
    end
endmodule

// File: rtl/lss_rsv.sv
module lss_rsv
    import lss_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic [1:0]          enq_v,
    input  mem_op_t [1:0]       enq_op,
    input  logic [1:0]          n_issue,
    output mem_op_t             head,
    output logic                head_v,
    output mem_op_t             nxt,
    output logic                nxt_v,
    output logic                ready
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        mem_op_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0]    cnt;
    } rsv_st_t;

    rsv_st_t st_d, st_q;
    logic [CNT_W-1:0] wr;
    logic             take;

    always_comb begin
        st_d = st_q;
        take = ready && !flush;
        for (int s = 0; s < 2; s++) begin
            if (n_issue > 2'(s)) begin
                for (int i = 0; i < DEPTH - 1; i++) st_d.ent[i] = st_d.ent[i+1];
                st_d.ent[DEPTH-1] = '0;
            end
        end
        wr = st_q.cnt - CNT_W'(n_issue);
        for (int l = 0; l < 2; l++) begin
            if (take && enq_v[l]) begin
                for (int i = 0; i < DEPTH; i++)
                    if (CNT_W'(i) == wr) st_d.ent[i] = enq_op[l];
                wr = wr + 1'b1;
            end
        end
        st_d.cnt = wr;
        if (flush) st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head   = st_q.ent[0];
    assign nxt    = st_q.ent[1];
    assign head_v = st_q.cnt >= CNT_W'(1);
    assign nxt_v  = st_q.cnt >= CNT_W'(2);
    assign ready  = st_q.cnt <= CNT_W'(DEPTH - 2);

    // R10
    rs_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
    // R10
    rs_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(n_issue) <= st_q.cnt);
endmodule

// File: rtl/lss_stbuf.sv
module lss_stbuf
    import lss_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    flush,
    input  logic    push,
    input  mem_op_t push_op,
    input  logic    pop,
    output logic    room,
    output logic    head_v,
    output mem_op_t head
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        mem_op_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0]    cnt;
    } sb_st_t;

    sb_st_t st_d, st_q;
    logic [CNT_W-1:0] wr;

    always_comb begin
        st_d = st_q;
        wr   = st_q.cnt;
        if (pop && head_v) begin
            for (int i = 0; i < DEPTH - 1; i++) st_d.ent[i] = st_q.ent[i+1];
            st_d.ent[DEPTH-1] = '0;
            wr = wr - 1'b1;
        end
        if (push) begin
            for (int i = 0; i < DEPTH; i++)
                if (CNT_W'(i) == wr) st_d.ent[i] = push_op;
            wr = wr + 1'b1;
        end
        st_d.cnt = wr;
        if (flush) st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign room   = st_q.cnt < CNT_W'(DEPTH);
    assign head_v = st_q.cnt != '0;
    assign head   = st_q.ent[0];

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> st_q.cnt < CNT_W'(DEPTH));
    // R9
    sb_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> st_q.cnt == '0);
endmodule

// File: rtl/lss_sched_top.sv
module lss_sched_top
    import lss_pkg::*;
#(
    parameter int RS_DEPTH = 4,
    parameter int SB_DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic [1:0]            enq_valid,
    input  logic [1:0]            enq_store,
    input  logic [2*ATTR_W-1:0]   enq_attr,
    input  logic [2*IDX_W-1:0]    enq_idx,
    input  logic [2*BANK_W-1:0]   enq_bank,
    input  logic [2*TAG_W-1:0]    enq_tag,
    input  logic [2*DATA_W-1:0]   enq_data,
    output logic                  enq_ready,
    output logic [1:0]            iss_valid,
    output logic [1:0]            iss_store,
    output logic [2*IDX_W-1:0]    iss_idx,
    output logic [2*BANK_W-1:0]   iss_bank,
    output logic [2*TAG_W-1:0]    iss_tag,
    input  logic                  commit,
    output logic                  drain_valid,
    output logic [IDX_W-1:0]      drain_idx,
    output logic [BANK_W-1:0]     drain_bank,
    output logic [DATA_W-1:0]     drain_data
);
    mem_op_t [1:0] enq_ops;
    mem_op_t       head, nxt, sb_head;
    logic          head_v, nxt_v, sb_room, go0, go1, g0, g1, sb_push;
    logic [1:0]    n_issue;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign enq_ops[g] = '{is_st: enq_store[g],
                              attr:  enq_attr[g*ATTR_W +: ATTR_W],
                              idx:   enq_idx[g*IDX_W +: IDX_W],
                              bank:  enq_bank[g*BANK_W +: BANK_W],
                              tag:   enq_tag[g*TAG_W +: TAG_W],
                              data:  enq_data[g*DATA_W +: DATA_W]};
    end

    lss_rsv #(.DEPTH(RS_DEPTH)) u_rsv (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .enq_v(enq_valid), .enq_op(enq_ops), .n_issue(n_issue),
        .head(head), .head_v(head_v), .nxt(nxt), .nxt_v(nxt_v),
        .ready(enq_ready)
    );

    lss_pair u_pair (
        .head(head), .head_v(head_v), .nxt(nxt), .nxt_v(nxt_v),
        .sb_room(sb_room), .go0(go0), .go1(go1)
    );

    always_comb begin
        g0      = go0 && !flush;
        g1      = go1 && !flush;
        n_issue = {1'b0, g0} + {1'b0, g1};
        sb_push = (g0 && head.is_st) || (g1 && nxt.is_st);
    end

    lss_stbuf #(.DEPTH(SB_DEPTH)) u_sb (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(sb_push), .push_op(head.is_st ? head : nxt),
        .pop(commit && !flush),
        .room(sb_room), .head_v(drain_valid), .head(sb_head)
    );

    assign iss_valid  = {g1, g0};
    assign iss_store  = {nxt.is_st, head.is_st};
    assign iss_idx    = {nxt.idx, head.idx};
    assign iss_bank   = {nxt.bank, head.bank};
    assign iss_tag    = {nxt.tag, head.tag};
    assign drain_idx  = sb_head.idx;
    assign drain_bank = sb_head.bank;
    assign drain_data = sb_head.data;

    // R4
    no_two_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid == 2'b11 |-> !(iss_store[0] && iss_store[1]));
    // R5
    no_slot_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid == 2'b11 && iss_store[0] != iss_store[1]) |->
        !(iss_idx[IDX_W-1:0] == iss_idx[2*IDX_W-1:IDX_W] &&
          iss_bank[BANK_W-1:0] == iss_bank[2*BANK_W-1:BANK_W]));
    // R6
    lone_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[1] |-> (head.attr == '0 && nxt.attr == '0));
    // R2
    port_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[1] |-> iss_valid[0]);
    // R9
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> iss_valid == 2'b00);
    // R7
    full_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sb_room |-> !((iss_valid[0] && iss_store[0]) || (iss_valid[1] && iss_store[1])));
endmodule

// File: tb/lss_sched_top_tb.sv
module lss_sched_top_tb;
    import lss_pkg::*;

    logic                clk = 0, rst_n = 0, flush = 0, commit = 0;
    logic [1:0]          enq_valid = 0, enq_store = 0;
    logic [2*ATTR_W-1:0] enq_attr = 0;
    logic [2*IDX_W-1:0]  enq_idx = 0;
    logic [2*BANK_W-1:0] enq_bank = 0;
    logic [2*TAG_W-1:0]  enq_tag = 0;
    logic [2*DATA_W-1:0] enq_data = 0;
    logic                enq_ready, drain_valid;
    logic [1:0]          iss_valid, iss_store;
    logic [2*IDX_W-1:0]  iss_idx;
    logic [2*BANK_W-1:0] iss_bank;
    logic [2*TAG_W-1:0]  iss_tag;
    logic [IDX_W-1:0]    drain_idx;
    logic [BANK_W-1:0]   drain_bank;
    logic [DATA_W-1:0]   drain_data;

    int checks = 0, errors = 0;
    int exp_q[$];

    always #4 clk = ~clk;

    lss_sched_top u_dut (.*);

    function automatic mem_op_t mk(bit st, logic [ATTR_W-1:0] at, logic [IDX_W-1:0] ix,
                                   logic [BANK_W-1:0] bk, logic [TAG_W-1:0] tg);
        return '{is_st: st, attr: at, idx: ix, bank: bk, tag: tg, data: {4'hC, 2'b00, ix, tg}};
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(mem_op_t a, bit va, mem_op_t b, bit vb);
        @(posedge clk); #1;
        enq_valid = {vb, va};
        enq_store = {b.is_st, a.is_st};
        enq_attr  = {b.attr, a.attr};
        enq_idx   = {b.idx, a.idx};
        enq_bank  = {b.bank, a.bank};
        enq_tag   = {b.tag, a.tag};
        enq_data  = {b.data, a.data};
        @(posedge clk); #1;
        enq_valid = 0;
    endtask

    task automatic expect_iss(int port, int tag);
        exp_q.push_back(port * 100 + tag);
    endtask

    task automatic settle();
        for (int i = 0; i < 40 && exp_q.size() != 0; i++) @(posedge clk);
        repeat (2) @(posedge clk);
        chk("R2 queue drained", exp_q.size(), 0);
    endtask

    task automatic pulse_commit();
        @(posedge clk); #1; commit = 1;
        @(posedge clk); #1; commit = 0;
    endtask

    // scoreboard monitor: every valid port must match the next expected item
    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < 2; p++) begin
                if (iss_valid[p]) begin
                    int got;
                    got = p * 100 + int'(iss_tag[p*TAG_W +: TAG_W]);
                    checks++;
                    if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL R2/R9 unexpected issue: actual %0d expected none", got);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        if (got != e) begin
                            errors++;
                            $display("FAIL R2-order issue: actual %0d expected %0d", got, e);
                        end
                    end
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1
        chk("R1 iss_valid", int'(iss_valid), 0);
        chk("R1 enq_ready", int'(enq_ready), 1);
        chk("R1 drain_valid", int'(drain_valid), 0);
        rst_n = 1;

        // R3 two loads pair
        expect_iss(0, 1); expect_iss(1, 2);
        send(mk(0, 0, 1, 0, 1), 1, mk(0, 0, 2, 0, 2), 1);
        settle();

        // R4 two stores never together
        expect_iss(0, 3); expect_iss(0, 4);
        send(mk(1, 0, 3, 0, 3), 1, mk(1, 0, 4, 1, 4), 1);
        settle();

        // R5 same index and bank: split
        expect_iss(0, 5); expect_iss(0, 6);
        send(mk(0, 0, 5, 1, 5), 1, mk(1, 0, 5, 1, 6), 1);
        settle();

        // R5 same index, other bank: paired (store buffer now full)
        expect_iss(0, 7); expect_iss(1, 8);
        send(mk(0, 0, 5, 1, 7), 1, mk(1, 0, 5, 2, 8), 1);
        settle();

        // R7 full store buffer stalls the store at the head
        send(mk(1, 0, 9, 0, 9), 1, mk(0, 0, 10, 0, 10), 1);
        @(negedge clk);
        chk("R7 stalled store", int'(iss_valid), 0);
        chk("R10 ready with two free", int'(enq_ready), 1);
        send(mk(0, 0, 11, 0, 11), 1, mk(0, 0, 12, 0, 12), 1);
        @(negedge clk);
        chk("R10 ready when full", int'(enq_ready), 0);
        chk("R7 still stalled", int'(iss_valid), 0);
        // R8 oldest store shown
        chk("R8 drain_valid", int'(drain_valid), 1);
        chk("R8 drain data tag3", int'(drain_data), int'(mk(1, 0, 3, 0, 3).data));
        chk("R8 drain idx tag3", int'(drain_idx), 3);
        expect_iss(0, 9); expect_iss(1, 10); expect_iss(0, 11); expect_iss(1, 12);
        pulse_commit();
        settle();
        chk("R10 ready after drain", int'(enq_ready), 1);

        // R8 order of release
        #1;
        chk("R8 drain tag4", int'(drain_data), int'(mk(1, 0, 4, 1, 4).data));
        chk("R8 drain bank tag4", int'(drain_bank), 1);
        pulse_commit();
        chk("R8 drain tag6", int'(drain_data), int'(mk(1, 0, 5, 1, 6).data));
        pulse_commit();
        chk("R8 drain tag8", int'(drain_data), int'(mk(1, 0, 5, 2, 8).data));

        // R6 attribute bit 0 on the older, bit 4 on the younger
        expect_iss(0, 13); expect_iss(0, 14);
        send(mk(0, 5'b00001, 13, 0, 13), 1, mk(0, 0, 14, 1, 14), 1);
        settle();
        expect_iss(0, 15); expect_iss(0, 1);
        send(mk(0, 0, 15, 0, 15), 1, mk(0, 5'b10000, 16, 1, 1), 1);
        settle();

        // R9 flush with queued stores and held store-buffer entries
        chk("R9 buffer holds before flush", int'(drain_valid), 1);
        send(mk(1, 0, 20, 0, 2), 1, mk(1, 0, 21, 0, 3), 1);
        flush = 1;
        @(negedge clk);
        chk("R9 quiet during flush", int'(iss_valid), 0);
        @(posedge clk); #1; flush = 0;
        @(negedge clk);
        chk("R9 no issue after flush", int'(iss_valid), 0);
        chk("R9 store buffer empty", int'(drain_valid), 0);
        chk("R9 queue empty", int'(enq_ready), 1);

        // R3 normal pairing afterwards
        expect_iss(0, 6); expect_iss(1, 7);
        send(mk(0, 0, 30, 0, 6), 1, mk(0, 0, 31, 3, 7), 1);
        settle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule